// File: doc/BRIEF.md
# Power Button Debounce Controller

This block conditions the asynchronous, active-low power-button pin of a power-management controller. It runs on the 32.768 kHz low-power clock: one clock cycle is one tick. The pin is brought into the clock domain by a two-stage synchronizer. The synchronized level is presented to software as a raw sense bit with no filtering. A single age counter measures how long the synchronized level has held since it last changed. Any change of level restarts the measurement.

A two-bit setting picks one of four debounce profiles. Each profile gives three qualification times. The first is for the turn-on request sent to the power sequencer. The second is for the press (falling-edge) interrupt. The third is for the release (rising-edge) interrupt. A qualified press yields a one-cycle turn-on request. Each qualified edge sets a sticky interrupt flag. Software clears a flag by writing 1 to it. A per-flag mask keeps a flag off the combined interrupt line, but the flag still records the event.

Top module: `pwrbtn_debounce`

## Requirements
- R1: After reset, sense is 1, turn_on_req is 0, irq_flags is 2'b00 and irq is 0. No event fires while the pin holds the level it had during reset.
- R2: sense equals the pin level sampled through two flops. A pin change made just after clock edge c appears on sense after edge c+2. A pulse of a few cycles, far too short to qualify, still shows on sense.
- R3: With dbnc_sel=2'b00, the turn-on request needs no stable time. A pin press made after edge c pulses turn_on_req in the cycle after edge c+3. The press flag needs 1024 stable ticks. The release flag needs 1024 stable ticks.
- R4: With dbnc_sel=2'b01, the turn-on, press and release qualifications each need 1024 stable ticks.
- R5: With dbnc_sel=2'b10, the turn-on and press qualifications need 4096 stable ticks. The release qualification needs 1024 stable ticks.
- R6: With dbnc_sel=2'b11, the turn-on and press qualifications need 24576 stable ticks. The release qualification needs 1024 stable ticks.
- R7: An event with qualification time T, for a pin level driven after edge c, registers its output at edge c+3+T. This happens only if the pin holds for more than T cycles. A hold of exactly T cycles does not qualify. Any level change before then restarts the count.
- R8: turn_on_req is a single-cycle pulse. It is issued once per qualified press, however long the button stays down.
- R9: irq_flags[0] is the press flag and irq_flags[1] is the release flag. Each is sticky until a cycle with the matching flag_clr bit at 1. Clearing one flag leaves the other unchanged.
- R10: irq_mask[0] masks the press flag and irq_mask[1] masks the release flag. A masked flag still sets. irq is the OR of the flags whose mask bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz tick clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_n_pin | input | 1 | Asynchronous button pin, 0 = pressed |
| dbnc_sel | input | 2 | Debounce profile select |
| irq_mask | input | 2 | Mask bits: [0] press, [1] release |
| flag_clr | input | 2 | Write-1-to-clear strobes: [0] press, [1] release |
| sense | output | 1 | Synchronized, unfiltered pin level |
| turn_on_req | output | 1 | One-cycle qualified turn-on request |
| irq_flags | output | 2 | Sticky flags: [0] press, [1] release |
| irq | output | 1 | Combined unmasked interrupt |

## Verification
Clean presses and releases are run under all four profiles. This shows that each profile applies the right time to each of the three paths, and that the instant profile fires turn-on before the press flag. Short glitches and interrupted holds below the qualification time show that a level change restarts the count rather than adding to it. Holds of exactly the threshold and one cycle past it separate a correct strict comparison from an off-by-one. A long held press confirms the single turn-on pulse. Mask and clear sequences on a set flag separate flag recording from interrupt signalling.

// File: rtl/pbd_pkg.sv
package pbd_pkg;

    typedef enum logic [1:0] {
        DB_INSTANT = 2'b00,
        DB_SHORT   = 2'b01,
        DB_MEDIUM  = 2'b10,
        DB_LONG    = 2'b11
    } dbnc_mode_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic on;
    } qual_t;

    localparam int FLAG_FALL = 0;
    localparam int FLAG_RISE = 1;
    localparam int NUM_FLAGS = 2;

    // stable ticks needed before a turn-on request
    function automatic int on_ticks(dbnc_mode_e m, int ts, int tm, int tl);
        case (m)
            DB_INSTANT: return 0;
            DB_SHORT:   return ts;
            DB_MEDIUM:  return tm;
            default:    return tl;
        endcase
    endfunction

    // stable ticks needed before the press flag sets
    function automatic int fall_ticks(dbnc_mode_e m, int ts, int tm, int tl);
        case (m)
            DB_INSTANT,
            DB_SHORT:   return ts;
            DB_MEDIUM:  return tm;
            default:    return tl;
        endcase
    endfunction

endpackage

// File: rtl/pbd_sync.sv
module pbd_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pbd_age.sv
module pbd_age #(
    parameter int CW = 15
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lvl,
    output logic [CW-1:0] age
);
    localparam logic [CW-1:0] AGE_MAX = '1;

    logic          prev;
    logic [CW-1:0] age_r;
    logic          changed;

    assign changed = lvl ^ prev;
    // age is 0 in the first cycle of a new level
    assign age     = changed ? '0 : age_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev  <= 1'b1;
            age_r <= AGE_MAX;   // saturated: nothing qualifies out of reset
        end else begin
            prev <= lvl;
            if (changed)
                age_r <= CW'(1);
            else if (age_r != AGE_MAX)
                age_r <= age_r + CW'(1);
        end
    end
endmodule

// File: rtl/pbd_flags.sv
module pbd_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] mask,
    output logic [N-1:0] flags,
    output logic         irq
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)         flags[g] <= 1'b0;
            else if (set[g]) flags[g] <= 1'b1;   // a new event beats a clear
            else if (clr[g]) flags[g] <= 1'b0;
        end
    end

    assign irq = |(flags & ~mask);
endmodule

// File: rtl/pwrbtn_debounce.sv
module pwrbtn_debounce
    import pbd_pkg::*;
#(
    parameter int T_SHORT     = 1024,
    parameter int T_MEDIUM    = 4096,
    parameter int T_LONG      = 24576,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       btn_n_pin,
    input  logic [1:0] dbnc_sel,
    input  logic [1:0] irq_mask,
    input  logic [1:0] flag_clr,
    output logic       sense,
    output logic       turn_on_req,
    output logic [1:0] irq_flags,
    output logic       irq
);
    localparam int CW = $clog2(T_LONG + 2);
    localparam logic [CW-1:0] TH_RISE = CW'(T_SHORT);

    logic            lvl;
    logic [CW-1:0]   age;
    logic [CW-1:0]   th_on;
    logic [CW-1:0]   th_fall;
    dbnc_mode_e      mode;
    qual_t           fire;
    logic [NUM_FLAGS-1:0] set_vec;

    pbd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (btn_n_pin),
        .q   (lvl)
    );

    assign sense = lvl;

    pbd_age #(.CW(CW)) u_age (
        .clk (clk),
        .rst (rst),
        .lvl (lvl),
        .age (age)
    );

    assign mode = dbnc_mode_e'(dbnc_sel);

    always_comb begin
        th_on     = CW'(on_ticks(mode, T_SHORT, T_MEDIUM, T_LONG));
        th_fall   = CW'(fall_ticks(mode, T_SHORT, T_MEDIUM, T_LONG));
        // equality fires each qualification exactly once per held level
        fire.on   = !lvl && (age == th_on);
        fire.fall = !lvl && (age == th_fall);
        fire.rise =  lvl && (age == TH_RISE);
    end

    always_ff @(posedge clk) begin
        if (rst) turn_on_req <= 1'b0;
        else     turn_on_req <= fire.on;
    end

    always_comb begin
        set_vec            = '0;
        set_vec[FLAG_FALL] = fire.fall;
        set_vec[FLAG_RISE] = fire.rise;
    end

    pbd_flags #(.N(NUM_FLAGS)) u_flags (
        .clk   (clk),
        .rst   (rst),
        .set   (set_vec),
        .clr   (flag_clr),
        .mask  (irq_mask),
        .flags (irq_flags),
        .irq   (irq)
    );
endmodule

// File: rtl/pwrbtn_debounce_chk.sv
module pwrbtn_debounce_chk (
    input logic       clk,
    input logic       rst,
    input logic       sense,
    input logic       turn_on_req,
    input logic [1:0] irq_flags,
    input logic [1:0] irq_mask,
    input logic [1:0] flag_clr,
    input logic [1:0] set_vec,
    input logic       irq
);
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        turn_on_req |=> !turn_on_req); // R8

    AST_ON_FROM_PRESS: assert property (@(posedge clk) disable iff (rst)
        turn_on_req |-> $past(!sense)); // R8

    AST_FALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (irq_flags[0] && !flag_clr[0]) |=> irq_flags[0]); // R9

    AST_RISE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (irq_flags[1] && !flag_clr[1]) |=> irq_flags[1]); // R9

    AST_FALL_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (flag_clr[0] && !set_vec[0]) |=> !irq_flags[0]); // R9

    AST_RISE_FROM_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_flags[1]) |-> $past(sense)); // R9

    AST_MASKED_STILL_SETS: assert property (@(posedge clk) disable iff (rst)
        set_vec[0] |=> irq_flags[0]); // R10

    AST_ALL_MASKED: assert property (@(posedge clk) disable iff (rst)
        (irq_mask == 2'b11) |-> !irq); // R10

    AST_NO_FLAG_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
        (irq_flags == 2'b00) |-> !irq); // R10
endmodule

bind pwrbtn_debounce pwrbtn_debounce_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .sense       (sense),
    .turn_on_req (turn_on_req),
    .irq_flags   (irq_flags),
    .irq_mask    (irq_mask),
    .flag_clr    (flag_clr),
    .set_vec     (set_vec),
    .irq         (irq)
);

// File: tb/tb_pwrbtn_debounce.sv
`timescale 1ns/1ps
module tb_pwrbtn_debounce;

    localparam int EV_ON   = 0;
    localparam int EV_FALL = 1;
    localparam int EV_RISE = 2;

    typedef struct {
        int    kind;
        int    cyc;
        string req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst;
    logic       btn_n_pin;
    logic [1:0] dbnc_sel;
    logic [1:0] irq_mask;
    logic [1:0] flag_clr;
    logic       sense;
    logic       turn_on_req;
    logic [1:0] irq_flags;
    logic       irq;

    int   cyc = 0;
    int   total = 0;
    int   bad = 0;
    int   on_seen = 0;
    bit   mon_en = 0;
    logic prev_f = 1'b0;
    logic prev_r = 1'b0;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pwrbtn_debounce dut (
        .clk         (clk),
        .rst         (rst),
        .btn_n_pin   (btn_n_pin),
        .dbnc_sel    (dbnc_sel),
        .irq_mask    (irq_mask),
        .flag_clr    (flag_clr),
        .sense       (sense),
        .turn_on_req (turn_on_req),
        .irq_flags   (irq_flags),
        .irq         (irq)
    );

    function automatic string kname(int k);
        case (k)
            EV_ON:   return "turn_on";
            EV_FALL: return "press_flag";
            default: return "release_flag";
        endcase
    endfunction

    // qualification times taken from the requirements R3..R6
    function automatic int t_on(logic [1:0] s);
        case (s)
            2'b00:   return 0;
            2'b01:   return 1024;
            2'b10:   return 4096;
            default: return 24576;
        endcase
    endfunction

    function automatic int t_fall(logic [1:0] s);
        case (s)
            2'b00, 2'b01: return 1024;
            2'b10:        return 4096;
            default:      return 24576;
        endcase
    endfunction

    function automatic void check(bit ok, string req, string what, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endfunction

    function automatic void match(int k);
        total++;
        if (exp_q.size() == 0) begin
            bad++;
            $display("FAIL unexpected %s: actual cycle=%0d expected none", kname(k), cyc);
        end else if (exp_q[0].kind != k || exp_q[0].cyc != cyc) begin
            bad++;
            $display("FAIL %s: actual %s at cycle %0d expected %s at cycle %0d",
                     exp_q[0].req, kname(k), cyc, kname(exp_q[0].kind), exp_q[0].cyc);
        end else begin
            void'(exp_q.pop_front());
        end
    endfunction

    // monitor: compares observed events with the scoreboard queue
    always @(negedge clk) begin
        if (mon_en) begin
            while (exp_q.size() > 0 && exp_q[0].cyc < cyc) begin
                total++;
                bad++;
                $display("FAIL %s: missing %s actual=none expected cycle=%0d",
                         exp_q[0].req, kname(exp_q[0].kind), exp_q[0].cyc);
                void'(exp_q.pop_front());
            end
            if (turn_on_req) begin
                on_seen++;
                match(EV_ON);
            end
            if (irq_flags[0] && !prev_f) match(EV_FALL);
            if (irq_flags[1] && !prev_r) match(EV_RISE);
            prev_f = irq_flags[0];
            prev_r = irq_flags[1];
        end
    end

    function automatic void push(int k, int c, string req);
        exp_t e;
        e.kind = k;
        e.cyc  = c;
        e.req  = req;
        exp_q.push_back(e);
    endfunction

    // driver: holds the pin at lvl for h cycles; called just after a rising edge
    task automatic seg(input logic lvl, input int h, input string req, input bit clr_end = 1'b1);
        int c;
        c = cyc;
        btn_n_pin = lvl;
        if (!lvl) begin
            if (t_on(dbnc_sel) < h)   push(EV_ON,   c + 3 + t_on(dbnc_sel),   req);
            if (t_fall(dbnc_sel) < h) push(EV_FALL, c + 3 + t_fall(dbnc_sel), req);
        end else begin
            if (1024 < h) push(EV_RISE, c + 3 + 1024, req);
        end
        repeat (h - 1) @(posedge clk);
        #1;
        if (clr_end) flag_clr = 2'b11;
        @(posedge clk);
        #1;
        flag_clr = 2'b00;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n0;
        rst       = 1'b1;
        btn_n_pin = 1'b1;
        dbnc_sel  = 2'b00;
        irq_mask  = 2'b00;
        flag_clr  = 2'b00;
        repeat (4) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        check(sense == 1'b1,       "R1", "sense after reset",    sense,       1);
        check(turn_on_req == 1'b0, "R1", "turn_on after reset",  turn_on_req, 0);
        check(irq_flags == 2'b00,  "R1", "flags after reset",    irq_flags,   0);
        check(irq == 1'b0,         "R1", "irq after reset",      irq,         0);
        mon_en = 1'b1;
        repeat (50) @(negedge clk);
        check(irq_flags == 2'b00 && !turn_on_req, "R1", "no event at idle", irq_flags, 0);
        @(posedge clk);
        #1;

        // instant profile
        dbnc_sel = 2'b00;
        seg(1'b0, 2000, "R3");
        seg(1'b1, 2000, "R3");

        // short profile with glitches that must restart the count
        dbnc_sel = 2'b01;
        seg(1'b0, 500,  "R7");
        seg(1'b1, 100,  "R7");
        seg(1'b0, 1500, "R4");
        seg(1'b1, 1500, "R4");

        // exact-threshold boundaries
        seg(1'b0, 1024, "R7");
        seg(1'b1, 1025, "R7");
        seg(1'b0, 1025, "R7");
        seg(1'b1, 1024, "R7");

        // medium profile
        dbnc_sel = 2'b10;
        seg(1'b0, 5000, "R5");
        seg(1'b1, 2000, "R5");

        // long profile, then a press released before it qualifies
        dbnc_sel = 2'b11;
        seg(1'b0, 26000, "R6");
        seg(1'b1, 1100,  "R6");
        seg(1'b0, 20000, "R7");
        seg(1'b1, 1100,  "R6");

        // one pulse per long press
        dbnc_sel = 2'b00;
        n0 = on_seen;
        seg(1'b0, 3000, "R8");
        seg(1'b1, 1100, "R8");
        check(on_seen - n0 == 1, "R8", "turn_on pulses per press", on_seen - n0, 1);

        // sense follows a short glitch unfiltered
        dbnc_sel = 2'b01;
        @(posedge clk);
        #1;
        btn_n_pin = 1'b0;
        @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        check(sense == 1'b1, "R2", "sense one edge after change", sense, 1);
        @(posedge clk);
        @(negedge clk);
        check(sense == 1'b0, "R2", "sense two edges after change", sense, 0);
        @(posedge clk);
        #1;
        seg(1'b1, 1500, "R2");

        // masking and clearing
        dbnc_sel = 2'b00;
        irq_mask = 2'b01;
        seg(1'b0, 1100, "R10", 1'b0);
        @(negedge clk);
        check(irq_flags[0] == 1'b1, "R10", "masked press flag set", irq_flags[0], 1);
        check(irq == 1'b0,          "R10", "irq with press masked", irq, 0);
        @(posedge clk);
        #1;
        irq_mask = 2'b00;
        @(negedge clk);
        check(irq == 1'b1, "R10", "irq with press unmasked", irq, 1);
        @(posedge clk);
        #1;
        flag_clr = 2'b01;
        @(posedge clk);
        #1;
        flag_clr = 2'b00;
        @(negedge clk);
        check(irq_flags[0] == 1'b0, "R9", "press flag after clear", irq_flags[0], 0);
        check(irq == 1'b0,          "R9", "irq after clear",        irq, 0);
        @(posedge clk);
        #1;
        seg(1'b1, 1100, "R9", 1'b0);
        @(negedge clk);
        check(irq_flags == 2'b10, "R9", "release flag sticky", irq_flags, 2);
        check(irq == 1'b1,        "R9", "irq from release flag", irq, 1);
        @(posedge clk);
        #1;
        irq_mask = 2'b10;
        @(negedge clk);
        check(irq == 1'b0, "R10", "irq with release masked", irq, 0);
        check(irq_flags[1] == 1'b1, "R10", "masked flag kept", irq_flags[1], 1);
        @(posedge clk);
        #1;
        flag_clr = 2'b11;
        @(posedge clk);
        #1;
        flag_clr = 2'b00;
        repeat (20) @(negedge clk);
        check(irq_flags == 2'b00, "R9", "flags after final clear", irq_flags, 0);
        check(exp_q.size() == 0, "R7", "pending expected events", exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule